// File: doc/BRIEF.md
# Double-Width Funnel Shifter

This block shifts a 64-bit word A left or right by a count taken from the bottom six bits of a second operand B. The bit positions that the shift empties are refilled from a third word C. The bits that fall off the end of A come back as a second 64-bit word, called the spill word. Used in pairs, the two words carry a shift across a multi-word value: the spill from one word becomes the fill for the next.

A direction input selects a left shift (0) or a right shift (1). Both directions use the same rotator and the same mask generator. A is rotated, and a keep-mask of 64-n ones decides, bit by bit, whether the main result takes the rotated A or C. The rotated bits outside the mask form the spill word.

When the record input is set, the block reports overflow, meaning the spill word is nonzero. It also produces a 4-bit condition field that classifies the main result as a signed number. By default, all outputs are registered once, with a synchronous active-high reset.

Top module: `fsh_funnel_unit`

## Requirements
- R1: The shift count n is b_i[5:0] (0 to 63). Bits b_i[63:6] have no effect on any output.
- R2: Left shift (dir_i=0): main_o equals A shifted left by n, with bits [n-1:0] taken from C[n-1:0].
- R3: Left shift: spill_o[n-1:0] holds A[63:64-n], and every other spill_o bit is zero.
- R4: Right shift (dir_i=1): main_o equals A shifted right by n, with bits [63:64-n] taken from C[63:64-n].
- R5: Right shift: spill_o[63:64-n] holds A[n-1:0], and every other spill_o bit is zero.
- R6: When n is 0, main_o equals A and spill_o is zero, in both directions.
- R7: ovf_o is 1 exactly when rec_en_i is 1 and spill_o is nonzero. It is 0 whenever rec_en_i is 0.
- R8: With rec_en_i=1, cond_o[3] is 1 when main_o is negative as a signed value, cond_o[2] is 1 when it is positive, cond_o[1] is 1 when it is zero, and cond_o[0] equals ovf_o. With rec_en_i=0, cond_o is 0.
- R9: With OUT_REG=1 (the default), the outputs reflect the inputs present at the previous rising clock edge. A synchronous reset drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | Shift direction: 0 for left, 1 for right |
| rec_en_i | input | 1 | Enables the overflow and condition outputs |
| a_i | input | 64 | Word to be shifted |
| b_i | input | 64 | Count operand; only bits [5:0] are used |
| c_i | input | 64 | Fill word for the vacated positions |
| main_o | output | 64 | Shifted A merged with the fill bits |
| spill_o | output | 64 | Bits shifted out of A |
| ovf_o | output | 1 | Spill word is nonzero (when recording) |
| cond_o | output | 4 | Condition field {neg, pos, zero, ovf} |

## Verification
The checker assumes that the inputs sampled at one edge, with reset low, produce the outputs seen at the next edge. It also assumes that the count bits it watches are b_i[5:0] and nothing wider. The stimulus holds each operand set for exactly one clock period and changes the inputs only on the falling edge. It sweeps every count in both directions, with several operand patterns, and sets bits in B[63:6] that must be ignored. Reset is applied only at the start, so the reset-clear property and the property linking the count to the spill word are both exercised on clean cycles.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

    localparam int unsigned FSH_WORD_W = 64;

    typedef enum logic {
        FSH_DIR_LEFT  = 1'b0,
        FSH_DIR_RIGHT = 1'b1
    } fsh_dir_e;

    // Condition field, packed MSB first: {neg, pos, zero, ovf}
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic ovf;
    } fsh_cond_t;

    function automatic fsh_cond_t fsh_make_cond(logic sign_bit, logic is_zero,
                                                logic spill_nz, logic rec);
        fsh_cond_t c;
        c.neg  = rec & sign_bit;
        c.pos  = rec & ~sign_bit & ~is_zero;
        c.zero = rec & is_zero;
        c.ovf  = rec & spill_nz;
        return c;
    endfunction

endpackage

// File: rtl/fsh_rotl.sv
module fsh_rotl #(
    parameter int unsigned W   = 64,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stage [SHW+1];

    assign stage[0] = din;

    // Logarithmic barrel: stage g rotates by 2**g when amt[g] is set
    for (genvar g = 0; g < SHW; g++) begin : g_stage
        localparam int unsigned STEP = 1 << g;
        assign stage[g+1] = amt[g] ? ((stage[g] << STEP) | (stage[g] >> (W - STEP)))
                                   : stage[g];
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/fsh_mask.sv
module fsh_mask #(
    parameter int unsigned W   = 64,
    parameter int unsigned SHW = $clog2(W)
) (
    input  fsh_pkg::fsh_dir_e dir,
    input  logic [SHW-1:0]    n,
    output logic [W-1:0]      keep
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    // Left: ones in [W-1:n]; right: ones in [W-1-n:0]
    always_comb begin
        if (dir == fsh_pkg::FSH_DIR_LEFT) keep = ALL_ONES << n;
        else                              keep = ALL_ONES >> n;
    end
endmodule

// File: rtl/fsh_merge.sv
module fsh_merge #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] rot,
    input  logic [W-1:0] keep,
    input  logic [W-1:0] fill,
    output logic [W-1:0] main_w,
    output logic [W-1:0] spill_w
);
    assign main_w  = (rot & keep) | (fill & ~keep);
    assign spill_w = rot & ~keep;
endmodule

// File: rtl/fsh_funnel_unit.sv
module fsh_funnel_unit #(
    parameter int unsigned W       = fsh_pkg::FSH_WORD_W,
    parameter bit          OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_i,
    input  logic         rec_en_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] main_o,
    output logic [W-1:0] spill_o,
    output logic         ovf_o,
    output logic [3:0]   cond_o
);
    import fsh_pkg::*;

    localparam int unsigned    SHW   = $clog2(W);
    localparam logic [W-1:0]   W_VEC = W;

    fsh_dir_e         dir;
    logic [SHW-1:0]   cnt;
    logic [SHW-1:0]   rot_amt;
    logic [W-1:0]     rotated;
    logic [W-1:0]     keep;
    logic [W-1:0]     main_w;
    logic [W-1:0]     spill_w;
    fsh_cond_t        cond_w;

    assign dir = fsh_dir_e'(dir_i);
    // Count is B modulo the word width: its low SHW bits
    assign cnt = SHW'(b_i % W_VEC);
    // Right shift is a left rotate by (W - n) mod W
    assign rot_amt = (dir == FSH_DIR_LEFT) ? cnt : (SHW'(0) - cnt);

    fsh_rotl #(.W(W), .SHW(SHW)) rot_i (
        .din  (a_i),
        .amt  (rot_amt),
        .dout (rotated)
    );

    fsh_mask #(.W(W), .SHW(SHW)) mask_i (
        .dir  (dir),
        .n    (cnt),
        .keep (keep)
    );

    fsh_merge #(.W(W)) merge_i (
        .rot     (rotated),
        .keep    (keep),
        .fill    (c_i),
        .main_w  (main_w),
        .spill_w (spill_w)
    );

    assign cond_w = fsh_make_cond(main_w[W-1], (main_w == '0), (spill_w != '0), rec_en_i);

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                main_o  <= '0;
                spill_o <= '0;
                ovf_o   <= 1'b0;
                cond_o  <= '0;
            end else begin
                main_o  <= main_w;
                spill_o <= spill_w;
                ovf_o   <= cond_w.ovf;
                cond_o  <= cond_w;
            end
        end
    end else begin : g_comb
        assign main_o  = main_w;
        assign spill_o = spill_w;
        assign ovf_o   = cond_w.ovf;
        assign cond_o  = cond_w;
    end
endmodule

// File: rtl/fsh_funnel_chk.sv
module fsh_funnel_chk #(
    parameter int unsigned W       = 64,
    parameter int unsigned SHW     = 6,
    parameter bit          OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic           rec_en_i,
    input logic [SHW-1:0] n_i,
    input logic [W-1:0]   main_o,
    input logic [W-1:0]   spill_o,
    input logic           ovf_o,
    input logic [3:0]     cond_o
);
    assert_ovf_needs_spill_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (spill_o != '0));

    assert_sign_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cond_o[3:1]));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        cond_o[1] |-> (main_o == '0));

    assert_neg_flag_R8: assert property (@(posedge clk) disable iff (rst)
        cond_o[3] |-> main_o[W-1]);

    assert_ovf_class_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (cond_o[3:1] != 3'b000));

    if (OUT_REG) begin : g_reg_props
        assert_reset_clear_R9: assert property (@(posedge clk)
            rst |=> (main_o == '0 && spill_o == '0 && !ovf_o && cond_o == 4'd0));

        assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
            (n_i == '0) |=> (spill_o == '0));

        assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
            !rec_en_i |=> (!ovf_o && cond_o == 4'd0));
    end else begin : g_comb_props
        assert_zero_count_R6: assert property (@(posedge clk) disable iff (rst)
            (n_i == '0) |-> (spill_o == '0));

        assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
            !rec_en_i |-> (!ovf_o && cond_o == 4'd0));
    end
endmodule

bind fsh_funnel_unit fsh_funnel_chk #(
    .W       (W),
    .SHW     ($clog2(W)),
    .OUT_REG (OUT_REG)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .rec_en_i (rec_en_i),
    .n_i      (b_i[$clog2(W)-1:0]),
    .main_o   (main_o),
    .spill_o  (spill_o),
    .ovf_o    (ovf_o),
    .cond_o   (cond_o)
);

// File: tb/fsh_funnel_unit_tb_top.sv
module fsh_funnel_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_i = 1'b0;
    logic        rec_en_i = 1'b0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [63:0] c_i = '0;
    logic [63:0] main_o;
    logic [63:0] spill_o;
    logic        ovf_o;
    logic [3:0]  cond_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] prev_main = '0;

    always #10 clk = ~clk;  // 50 MHz

    fsh_funnel_unit dut_i (
        .clk(clk), .rst(rst), .dir_i(dir_i), .rec_en_i(rec_en_i),
        .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .main_o(main_o), .spill_o(spill_o), .ovf_o(ovf_o), .cond_o(cond_o)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic run_vec(input logic d, input logic r, input logic [63:0] a,
                           input logic [63:0] b, input logic [63:0] c);
        int n;
        logic [63:0] em, es;
        logic [3:0]  ec;
        logic        eo;
        n = int'(b[5:0]);  // R1: only b[5:0] forms the count
        if (!d) begin
            em = (a << n) | (c & ~({64{1'b1}} << n));
            es = (n == 0) ? 64'd0 : (a >> (64 - n));
        end else begin
            em = (a >> n) | (c & ~({64{1'b1}} >> n));
            es = (n == 0) ? 64'd0 : (a << (64 - n));
        end
        eo = r && (es != 64'd0);
        ec = r ? {em[63], (!em[63] && em != 64'd0), (em == 64'd0), eo} : 4'd0;
        @(negedge clk);
        dir_i = d; rec_en_i = r; a_i = a; b_i = b; c_i = c;
        #1;
        chk("R9 hold before edge", main_o, prev_main);
        @(posedge clk);
        #1;
        if (n == 0) begin
            chk("R6 main n=0", main_o, a);
            chk("R6 spill n=0", spill_o, 64'd0);
        end else begin
            chk(d ? "R4 right main" : "R2 left main", main_o, em);
            chk(d ? "R5 right spill" : "R3 left spill", spill_o, es);
        end
        chk("R7 overflow", {63'd0, ovf_o}, {63'd0, eo});
        chk("R8 condition", {60'd0, cond_o}, {60'd0, ec});
        prev_main = em;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                finish_run();
            end
        end
    end

    initial begin
        logic [63:0] pa [4];
        logic [63:0] pc [4];
        pa[0] = 64'h8000_0000_0000_0001; pc[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        pa[1] = 64'h0123_4567_89AB_CDEF; pc[1] = 64'hA5A5_5A5A_C3C3_3C3C;
        pa[2] = 64'h0000_0000_0000_0000; pc[2] = 64'h0000_0000_0000_0000;
        pa[3] = 64'hFFFF_FFFF_FFFF_FFFF; pc[3] = 64'h1357_9BDF_0246_8ACE;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset clears every output
        chk("R9 reset main", main_o, 64'd0);
        chk("R9 reset spill", spill_o, 64'd0);
        chk("R9 reset flags", {59'd0, ovf_o, cond_o}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 4; p++) begin
                for (int n = 0; n < 64; n++) begin
                    // R1: upper bits of B vary and must not matter
                    logic [63:0] hi;
                    hi = {pa[p][57:0] ^ {29{2'(n)}}, 6'd0};
                    run_vec(d[0], n[0] ^ p[0], pa[p], hi | 64'(n), pc[p]);
                    run_vec(d[0], 1'b1, pa[p], ~hi & ~64'h3F | 64'(n), pc[p]);
                end
            end
        end
        // R1: all upper bits set, count zero
        run_vec(1'b0, 1'b1, 64'hDEAD_BEEF_0000_0001, 64'hFFFF_FFFF_FFFF_FFC0, 64'h0);
        // R8: result exactly zero with record set
        run_vec(1'b1, 1'b1, 64'h0000_0000_0000_00FF, 64'd8, 64'd0);
        finish_run();
    end

endmodule